// File: doc/BRIEF.md
# Chainable Two-Bit Processing Slice

This block is a narrow processing element for a microcoded datapath. Each slice works on a two-bit field of the operand word. It holds eleven general registers and one accumulator, and it performs addition, subtraction, logical functions, single-position shifts and bit testing. The top level chains a parameterised number of slices into one wider word. Carry ripples upward through the chain. Shift data passes between neighbouring slices on dedicated cascade lines. A per-slice zero flag feeds a word-wide zero detect.

An external sequencer supplies every control input. It drives a 7-bit function word, a register select, the external data word and the chain carry input on each cycle, and the slices execute that micro-operation in one clock. The result, the carry, the shift-out bits and the zero indication are combinational outputs of the current micro-operation. Writes into the register file or the accumulator take effect on the next rising clock edge.

The function word has three fields:
- bits 6:3 give the operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 pass the operand, 6 pass the accumulator, 7 shift left, 8 shift right, 9 bit test. Codes 10 to 15 are no-operations.
- bit 2 selects the operand source: 0 is the register addressed by the select input, 1 is the external data input.
- bits 1:0 select the destination: bit 0 writes the selected register, bit 1 writes the accumulator. Both bits may be set together.

Top module: `bitslice_alu`

## Requirements
- R1: After reset the accumulator and all eleven registers hold zero.
- R2: Opcode 0 gives result = (acc + operand + carryIn) mod 2^W, where W is the word width. carryOut is bit W of that sum, and the carry ripples across every slice.
- R3: Opcode 1 gives result = (acc + ~operand + carryIn) mod 2^W, and carryOut is bit W of that sum. With carryIn = 1, carryOut = 1 means no borrow occurred.
- R4: Opcodes 2, 3 and 4 give acc AND, OR and XOR operand respectively, with carryOut = 0 whatever carryIn is.
- R5: Function bit 2 picks the operand: 1 takes dataIn, 0 takes the register addressed by regSel. Opcode 5 passes the operand to the result, and opcode 6 passes the accumulator.
- R6: Destination bit 0 writes the result into the selected register and bit 1 writes it into the accumulator, at the next rising edge. Both may be set together. A storage element whose bit is clear keeps its value.
- R7: Opcode 7 gives result = {acc[W-2:0], shiftInLo}. shiftOutHi always shows acc[W-1].
- R8: Opcode 8 gives result = {shiftInHi, acc[W-1:1]}. shiftOutLo always shows acc[0].
- R9: zero is 1 exactly when every result bit is 0.
- R10: Opcode 9 gives result = acc AND operand for bit testing and writes nothing, whatever the destination bits say.
- R11: A regSel value of 11 or above reads as zero, and a write to it is ignored.
- R12: Opcodes 10 to 15 give a zero result and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| func | input | 7 | Function word: opcode, operand source, destination |
| regSel | input | 4 | Register select |
| dataIn | input | W | External operand word |
| carryIn | input | 1 | Carry into the lowest slice |
| shiftInLo | input | 1 | Bit entering the LSB on a left shift |
| shiftInHi | input | 1 | Bit entering the MSB on a right shift |
| result | output | W | Combinational result word |
| carryOut | output | 1 | Carry out of the highest slice |
| shiftOutHi | output | 1 | Accumulator MSB, the bit leaving on a left shift |
| shiftOutLo | output | 1 | Accumulator LSB, the bit leaving on a right shift |
| zero | output | 1 | Word-wide zero detect |

## Verification
The embedded properties check on every cycle that:
- the word zero flag matches the result;
- logical operations never raise a carry;
- the accumulator holds whenever it is not a destination and after a bit test;
- no-operation codes and out-of-range register reads produce zero.

Only the directed scenarios can show the following:
- the arithmetic values, including carries that ripple through all slices;
- the bits that shifts bring in at each end of the word;
- that each destination combination lands in the right register;
- that the register file is clear after reset.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_PASS = 4'd5,
    OP_ACC  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_TEST = 4'd9,
    OP_NOP  = 4'd15
  } opKindT;

  typedef struct packed {
    opKindT op;
    logic   srcExt;
    logic   rdValid;
    logic   wrReg;
    logic   wrAcc;
  } ctrlStrobeT;

endpackage

// File: rtl/slc_ctrl.sv
module slc_ctrl
  import slc_pkg::*;
#(
  parameter int NUM_REGS = 11,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [6:0]       func,
  input  logic [SEL_W-1:0] regSel,
  output ctrlStrobeT       strb
);

  logic selInRange;
  logic writable;

  always_comb begin
    selInRange = (int'(regSel) < NUM_REGS);
    strb       = '0;
    unique case (func[6:3])
      4'd0:    strb.op = OP_ADD;
      4'd1:    strb.op = OP_SUB;
      4'd2:    strb.op = OP_AND;
      4'd3:    strb.op = OP_OR;
      4'd4:    strb.op = OP_XOR;
      4'd5:    strb.op = OP_PASS;
      4'd6:    strb.op = OP_ACC;
      4'd7:    strb.op = OP_SHL;
      4'd8:    strb.op = OP_SHR;
      4'd9:    strb.op = OP_TEST;
      default: strb.op = OP_NOP;
    endcase
    writable     = (strb.op != OP_TEST) && (strb.op != OP_NOP);
    strb.srcExt  = func[2];
    strb.rdValid = selInRange;
    strb.wrReg   = func[0] && writable && selInRange;
    strb.wrAcc   = func[1] && writable;
  end

  // R11: a register write strobe must never point outside the file
  p_wr_in_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrReg |-> (int'(regSel) < NUM_REGS));

endmodule

// File: rtl/slc_slice.sv
module slc_slice
  import slc_pkg::*;
#(
  parameter int SLICE_W  = 2,
  parameter int NUM_REGS = 11,
  parameter int SEL_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [SLICE_W-1:0] dIn,
  input  logic               cIn,
  input  logic               shInLo,
  input  logic               shInHi,
  output logic [SLICE_W-1:0] res,
  output logic               cOut,
  output logic               shOutHi,
  output logic               shOutLo,
  output logic               zeroFlag
);

  logic [SLICE_W-1:0] regFile [NUM_REGS];
  logic [SLICE_W-1:0] acc;
  logic [SLICE_W-1:0] operand;
  logic [SLICE_W:0]   sumAdd;
  logic [SLICE_W:0]   sumSub;

  always_comb begin
    if (strb.srcExt)       operand = dIn;
    else if (strb.rdValid) operand = regFile[regSel];
    else                   operand = '0;
  end

  always_comb begin
    sumAdd = {1'b0, acc} + {1'b0, operand} + {{SLICE_W{1'b0}}, cIn};
    sumSub = {1'b0, acc} + {1'b0, ~operand} + {{SLICE_W{1'b0}}, cIn};
    res    = '0;
    cOut   = 1'b0;
    unique case (strb.op)
      OP_ADD:  begin res = sumAdd[SLICE_W-1:0]; cOut = sumAdd[SLICE_W]; end
      OP_SUB:  begin res = sumSub[SLICE_W-1:0]; cOut = sumSub[SLICE_W]; end
      OP_AND:  res = acc & operand;
      OP_OR:   res = acc | operand;
      OP_XOR:  res = acc ^ operand;
      OP_PASS: res = operand;
      OP_ACC:  res = acc;
      OP_SHL:  res = {acc[SLICE_W-2:0], shInLo};
      OP_SHR:  res = {shInHi, acc[SLICE_W-1:1]};
      OP_TEST: res = acc & operand;
      default: res = '0;
    endcase
  end

  assign shOutHi  = acc[SLICE_W-1];
  assign shOutLo  = acc[0];
  assign zeroFlag = (res == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (strb.wrAcc) acc <= res;
      if (strb.wrReg) regFile[regSel] <= res;
    end
  end

  // R4: logical functions leave the carry low
  p_logic_no_carry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.op == OP_AND || strb.op == OP_OR || strb.op == OP_XOR) |-> !cOut);

  // R6: accumulator keeps its value when it is not a destination
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrAcc |=> (acc == $past(acc)));

  // R10: a bit test never changes the accumulator
  p_test_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.op == OP_TEST) |=> $stable(acc));

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import slc_pkg::*;
#(
  parameter int SLICES   = 4,
  parameter int SLICE_W  = 2,
  parameter int NUM_REGS = 11,
  localparam int WORD_W  = SLICES * SLICE_W,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        func,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              carryIn,
  input  logic              shiftInLo,
  input  logic              shiftInHi,
  output logic [WORD_W-1:0] result,
  output logic              carryOut,
  output logic              shiftOutHi,
  output logic              shiftOutLo,
  output logic              zero
);

  ctrlStrobeT        strb;
  logic [SLICES:0]   carryChain;
  logic [SLICES:0]   shUp;
  logic [SLICES:0]   shDn;
  logic [SLICES-1:0] zeroVec;

  slc_ctrl #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .func(func), .regSel(regSel), .strb(strb)
  );

  assign carryChain[0] = carryIn;
  assign shUp[0]       = shiftInLo;
  assign shDn[SLICES]  = shiftInHi;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    slc_slice #(.SLICE_W(SLICE_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) i_slice (
      .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel),
      .dIn(dataIn[g*SLICE_W +: SLICE_W]),
      .cIn(carryChain[g]),
      .shInLo(shUp[g]),
      .shInHi(shDn[g+1]),
      .res(result[g*SLICE_W +: SLICE_W]),
      .cOut(carryChain[g+1]),
      .shOutHi(shUp[g+1]),
      .shOutLo(shDn[g]),
      .zeroFlag(zeroVec[g])
    );
  end

  assign carryOut   = carryChain[SLICES];
  assign shiftOutHi = shUp[SLICES];
  assign shiftOutLo = shDn[0];
  assign zero       = &zeroVec;

  // R9: combined zero flag agrees with the whole word
  p_zero_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    zero == (result == '0));

  // R12: unused opcodes yield a zero word
  p_nop_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (func[6:3] >= 4'd10) |-> (result == '0));

  // R11: passing an out-of-range register yields zero
  p_bad_sel_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (func[6:3] == 4'd5 && !func[2] && int'(regSel) >= NUM_REGS) |-> (result == '0));

endmodule

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [6:0]   func = '0;
  logic [3:0]   regSel = '0;
  logic [W-1:0] dataIn = '0;
  logic         carryIn = 1'b0;
  logic         shiftInLo = 1'b0;
  logic         shiftInHi = 1'b0;
  logic [W-1:0] result;
  logic         carryOut, shiftOutHi, shiftOutLo, zero;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  bitslice_alu i_bitslice_alu (
    .clk(clk), .rstN(rstN), .func(func), .regSel(regSel), .dataIn(dataIn),
    .carryIn(carryIn), .shiftInLo(shiftInLo), .shiftInHi(shiftInHi),
    .result(result), .carryOut(carryOut), .shiftOutHi(shiftOutHi),
    .shiftOutLo(shiftOutLo), .zero(zero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one micro-operation at the falling edge, settle before the rising edge
  task automatic apply(input logic [3:0] op, input logic src, input logic [1:0] dst,
                       input logic [3:0] sel, input logic [W-1:0] d, input logic ci,
                       input logic sLo = 1'b0, input logic sHi = 1'b0);
    @(negedge clk);
    func = {op, src, dst}; regSel = sel; dataIn = d; carryIn = ci;
    shiftInLo = sLo; shiftInHi = sHi;
    #2;
  endtask

  task automatic loadAcc(input logic [W-1:0] v);
    apply(4'd5, 1'b1, 2'b10, 4'd0, v, 1'b0);
  endtask

  task automatic loadReg(input logic [3:0] sel, input logic [W-1:0] v);
    apply(4'd5, 1'b1, 2'b01, sel, v, 1'b0);
  endtask

  task automatic readAcc(input string req, input logic [W-1:0] exp);
    apply(4'd6, 1'b0, 2'b00, 4'd0, '0, 1'b0);
    chk(req, result, exp);
  endtask

  task automatic readReg(input string req, input logic [3:0] sel, input logic [W-1:0] exp);
    apply(4'd5, 1'b0, 2'b00, sel, '0, 1'b0);
    chk(req, result, exp);
  endtask

  task automatic t_reset;
    readAcc("R1 acc after reset", 8'h00);
    chk("R9 zero after reset", zero, 1'b1);
    readReg("R1 reg0 after reset", 4'd0, 8'h00);
    readReg("R1 reg10 after reset", 4'd10, 8'h00);
  endtask

  task automatic t_dest;
    loadAcc(8'h5A);
    readAcc("R6 acc written", 8'h5A);
    loadReg(4'd2, 8'h3C);
    readAcc("R6 acc kept on reg-only write", 8'h5A);
    readReg("R5 R6 reg2 written", 4'd2, 8'h3C);
    apply(4'd5, 1'b1, 2'b11, 4'd4, 8'h11, 1'b0);
    readAcc("R6 both dest acc", 8'h11);
    readReg("R6 both dest reg4", 4'd4, 8'h11);
    apply(4'd5, 1'b1, 2'b00, 4'd4, 8'hFF, 1'b0);
    chk("R5 pass external", result, 8'hFF);
    readAcc("R6 no dest keeps acc", 8'h11);
    readReg("R6 no dest keeps reg4", 4'd4, 8'h11);
  endtask

  task automatic t_add;
    loadAcc(8'hF0);
    loadReg(4'd1, 8'h20);
    apply(4'd0, 1'b0, 2'b00, 4'd1, 8'h00, 1'b0);
    chk("R2 add reg result", result, 8'h10);
    chk("R2 add reg carry", carryOut, 1'b1);
    apply(4'd0, 1'b1, 2'b00, 4'd0, 8'h0E, 1'b1);
    chk("R2 add ext with cin", result, 8'hFF);
    chk("R2 add no carry", carryOut, 1'b0);
    chk("R9 nonzero", zero, 1'b0);
    loadAcc(8'h01);
    apply(4'd0, 1'b1, 2'b10, 4'd0, 8'hFF, 1'b0);
    chk("R2 ripple full word", result, 8'h00);
    chk("R2 ripple carry out", carryOut, 1'b1);
    chk("R9 zero on wrap", zero, 1'b1);
    readAcc("R2 sum written to acc", 8'h00);
  endtask

  task automatic t_sub;
    loadAcc(8'h50);
    apply(4'd1, 1'b1, 2'b00, 4'd0, 8'h20, 1'b1);
    chk("R3 sub result", result, 8'h30);
    chk("R3 sub no borrow", carryOut, 1'b1);
    loadAcc(8'h20);
    apply(4'd1, 1'b1, 2'b00, 4'd0, 8'h50, 1'b1);
    chk("R3 sub negative", result, 8'hD0);
    chk("R3 sub borrow", carryOut, 1'b0);
    apply(4'd1, 1'b1, 2'b00, 4'd0, 8'h20, 1'b0);
    chk("R3 sub cin low", result, 8'hFF);
  endtask

  task automatic t_logic;
    loadAcc(8'hCA);
    apply(4'd2, 1'b1, 2'b00, 4'd0, 8'h0F, 1'b1);
    chk("R4 and", result, 8'h0A);
    chk("R4 and carry", carryOut, 1'b0);
    apply(4'd3, 1'b1, 2'b00, 4'd0, 8'h0F, 1'b1);
    chk("R4 or", result, 8'hCF);
    apply(4'd4, 1'b1, 2'b00, 4'd0, 8'h0F, 1'b1);
    chk("R4 xor", result, 8'hC5);
    chk("R4 xor carry", carryOut, 1'b0);
  endtask

  task automatic t_shift;
    loadAcc(8'h96);
    apply(4'd7, 1'b0, 2'b00, 4'd0, '0, 1'b0, 1'b1, 1'b0);
    chk("R7 shl result", result, 8'h2D);
    chk("R7 shl out hi", shiftOutHi, 1'b1);
    apply(4'd8, 1'b0, 2'b00, 4'd0, '0, 1'b0, 1'b0, 1'b0);
    chk("R8 shr result", result, 8'h4B);
    chk("R8 shr out lo", shiftOutLo, 1'b0);
    apply(4'd8, 1'b0, 2'b00, 4'd0, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 shr fill hi", result, 8'hCB);
    apply(4'd7, 1'b0, 2'b10, 4'd0, '0, 1'b0, 1'b0, 1'b0);
    readAcc("R7 shl written back", 8'h2C);
    chk("R8 out lo after write", shiftOutLo, 1'b0);
    chk("R7 out hi after write", shiftOutHi, 1'b0);
  endtask

  task automatic t_test;
    loadReg(4'd5, 8'h66);
    loadAcc(8'h3C);
    apply(4'd9, 1'b1, 2'b11, 4'd5, 8'hC3, 1'b0);
    chk("R10 test result", result, 8'h00);
    chk("R10 R9 test zero", zero, 1'b1);
    apply(4'd9, 1'b1, 2'b11, 4'd5, 8'h04, 1'b0);
    chk("R10 test bit set", result, 8'h04);
    readAcc("R10 acc untouched", 8'h3C);
    readReg("R10 reg5 untouched", 4'd5, 8'h66);
  endtask

  task automatic t_badsel;
    loadAcc(8'h42);
    apply(4'd5, 1'b1, 2'b01, 4'd12, 8'h77, 1'b0);
    readReg("R11 sel12 reads zero", 4'd12, 8'h00);
    apply(4'd0, 1'b0, 2'b00, 4'd11, '0, 1'b0);
    chk("R11 sel11 operand zero", result, 8'h42);
    readAcc("R11 acc untouched", 8'h42);
    readReg("R11 reg10 untouched", 4'd10, 8'h00);
  endtask

  task automatic t_nop;
    loadAcc(8'h99);
    loadReg(4'd0, 8'h24);
    apply(4'd12, 1'b1, 2'b11, 4'd0, 8'hAB, 1'b1);
    chk("R12 nop result", result, 8'h00);
    apply(4'd15, 1'b1, 2'b11, 4'd0, 8'hAB, 1'b1);
    chk("R12 nop carry", carryOut, 1'b0);
    readAcc("R12 acc untouched", 8'h99);
    readReg("R12 reg0 untouched", 4'd0, 8'h24);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_dest();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_test();
    t_badsel();
    t_nop();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule